// File: doc/BRIEF.md
# Nested Two-Stage Address Walk Sequencer

This block turns a guest-virtual address into a host-physical address when two levels of page tables are stacked. The guest tables hold guest-physical pointers. Each such pointer has to pass through the second-stage table before the guest entry behind it can be fetched. The sequencer therefore alternates between two kinds of step. A translation step hands a guest-physical address to an external second-stage walker. A read step fetches one guest entry through a memory port.

After the fourth guest entry, the sequencer translates the resulting guest-physical page address one last time, and that result is the final host-physical address. A start/done handshake frames each walk. The block reports the final address, a fault code, the step number at which the walk stopped, and the total number of table-entry references made. For four guest levels over a four-level second stage, that total is 4·4+4+4 = 24.

Fault codes are 0 for success, 1 for a guest entry that is not present, and 2 for a fault reported by the second-stage walker. The second-stage walker reports, with each response, how many entries it referenced. The memory port returns an entry as two fields: its next-frame field (entry bits 51:12) and its present flag (entry bit 0).

Top module: `nested_walk_seq`

## Requirements
- R1: After reset, done, s2ReqValid and memReq are low, and fault and refCount are zero.
- R2: A start pulse while idle samples gva, guestRoot and s2Root. Later changes to these inputs have no effect on the walk, and every translation request carries the sampled root on s2ReqRoot.
- R3: The first request after start translates the sampled guest root. Requests then alternate strictly between entry read and translation, and a successful walk issues 5 translations and 4 reads. At most one request is outstanding, and s2ReqValid and memReq are never high together.
- R4: The address of the guest entry read at level k (k = 0 is the top) is the host base returned by the preceding translation plus 8 times the index. The index is taken from gva bits 47:39, 38:30, 29:21 and 20:12 for k = 0..3.
- R5: After reads 0 to 2, the next translated address is {memRspFrame, 12'h000}. After read 3 it is {memRspFrame, gva[11:0]}.
- R6: A walk without faults ends with hpa equal to the walker result for the fifth translation, fault = 0 and faultStep = 8.
- R7: refCount equals the sum of the s2RspRefs values received plus one per guest entry read. This is 24 for a full walk whose translations each report 4.
- R8: An entry returned with memRspPresent = 0 at read k ends the walk with fault = 1, faultStep = 2k+1 and hpa = 0. No further request is issued.
- R9: A response with s2RspFault = 1 at translation j ends the walk with fault = 2, faultStep = 2j and hpa = 0. refCount includes the references reported with the faulting response, and no further request is issued.
- R10: done is a one-cycle pulse. hpa, fault, faultStep and refCount keep their values until the next walk completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (accepted only while idle) |
| gva | input | 48 | Guest-virtual address to translate |
| guestRoot | input | 52 | Guest-physical address of the top guest table |
| s2Root | input | 52 | Root pointer for the second-stage walker |
| s2ReqValid | output | 1 | One-cycle translation request |
| s2ReqGpa | output | 52 | Guest-physical address to translate |
| s2ReqRoot | output | 52 | Second-stage root sampled at start |
| s2RspValid | input | 1 | Translation response strobe |
| s2RspHpa | input | 52 | Translated host-physical address |
| s2RspFault | input | 1 | Second-stage walk faulted |
| s2RspRefs | input | 3 | Entries referenced by that translation |
| memReq | output | 1 | One-cycle guest entry read request |
| memAddr | output | 52 | Host-physical address of the guest entry |
| memRspValid | input | 1 | Entry read response strobe |
| memRspFrame | input | 40 | Next-frame field of the entry (bits 51:12) |
| memRspPresent | input | 1 | Present flag of the entry (bit 0) |
| done | output | 1 | Walk finished, one-cycle pulse |
| hpa | output | 52 | Final host-physical address (0 on fault) |
| fault | output | 2 | 0 none, 1 guest not present, 2 second-stage fault |
| faultStep | output | 4 | Step at which the walk ended |
| refCount | output | 8 | Total entry references of the walk |

## Verification
The bench aims at the ends of the step sequence. It injects a missing guest entry at each of the four reads and walker faults at the first, middle and final translations. A design off by one in its step counting would report the wrong faultStep, or would keep issuing requests after the fault.

Addresses with all indices at 511 and at 0 exercise the index scaling and the top-down field order. A swapped field or a missing factor of 8 shows up as a wrong memAddr on the first read. Only the last level keeps the page offset, so a design that carries it on the wrong level reports a wrong hpa.

The bench changes the inputs right after start, which catches a design that reads gva or the roots live instead of sampling them. Random walker and memory latencies check that each response is taken exactly once and included in refCount exactly once.

// File: rtl/nws_pkg.sv
package nws_pkg;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_GUEST  = 2'd1,
    FLT_STAGE2 = 2'd2
  } faultKind_e;

  // Strobes from the sequencer to the datapath, valid for one cycle.
  typedef struct packed {
    logic       loadRoot;   // capture inputs, begin a walk
    logic       loadBase;   // take translated table base
    logic       loadNext;   // take next guest-physical address from entry
    logic       addS2Refs;  // add walker reference count
    logic       addOne;     // add one guest entry reference
    logic       finish;     // latch results
    faultKind_e kind;       // outcome when finishing
  } walkCtl_t;

endpackage

// File: rtl/nws_control.sv
module nws_control
  import nws_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int LVL_W  = 3,
  parameter int STEP_W = 4,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              s2RspValid,
  input  logic              s2RspFault,
  input  logic              memRspValid,
  input  logic              entryPresent,
  output walkCtl_t          ctl,
  output logic [SEL_W-1:0]  levelIdx,
  output logic              lastLevel,
  output logic [STEP_W-1:0] step,
  output logic              s2ReqValid,
  output logic              memReq,
  output logic              done
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_S2_ISSUE, ST_S2_WAIT, ST_RD_ISSUE, ST_RD_WAIT
  } state_e;

  state_e            state, stateNext;
  logic [LVL_W-1:0]  level, levelNext;
  logic [STEP_W-1:0] stepNext;
  logic              doneNext;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    levelNext = level;
    stepNext  = step;
    doneNext  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.loadRoot = 1'b1;
          levelNext    = '0;
          stepNext     = '0;
          stateNext    = ST_S2_ISSUE;
        end
      end
      ST_S2_ISSUE: stateNext = ST_S2_WAIT;
      ST_S2_WAIT: begin
        if (s2RspValid) begin
          ctl.addS2Refs = 1'b1;
          if (s2RspFault) begin
            ctl.finish = 1'b1;
            ctl.kind   = FLT_STAGE2;
            doneNext   = 1'b1;
            stateNext  = ST_IDLE;
          end else if (level == LVL_W'(LEVELS)) begin
            ctl.finish = 1'b1;
            ctl.kind   = FLT_NONE;
            doneNext   = 1'b1;
            stateNext  = ST_IDLE;
          end else begin
            ctl.loadBase = 1'b1;
            stepNext     = step + STEP_W'(1);
            stateNext    = ST_RD_ISSUE;
          end
        end
      end
      ST_RD_ISSUE: stateNext = ST_RD_WAIT;
      ST_RD_WAIT: begin
        if (memRspValid) begin
          ctl.addOne = 1'b1;
          if (!entryPresent) begin
            ctl.finish = 1'b1;
            ctl.kind   = FLT_GUEST;
            doneNext   = 1'b1;
            stateNext  = ST_IDLE;
          end else begin
            ctl.loadNext = 1'b1;
            levelNext    = level + LVL_W'(1);
            stepNext     = step + STEP_W'(1);
            stateNext    = ST_S2_ISSUE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      level <= '0;
      step  <= '0;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      level <= levelNext;
      step  <= stepNext;
      done  <= doneNext;
    end
  end

  assign levelIdx   = level[SEL_W-1:0];
  assign lastLevel  = (level == LVL_W'(LEVELS - 1));
  assign s2ReqValid = (state == ST_S2_ISSUE);
  assign memReq     = (state == ST_RD_ISSUE);

endmodule

// File: rtl/nws_datapath.sv
module nws_datapath
  import nws_pkg::*;
#(
  parameter int PA_W      = 52,
  parameter int VA_W      = 48,
  parameter int LEVELS    = 4,
  parameter int IDX_W     = 9,
  parameter int OFF_W     = 12,
  parameter int ENTRY_B   = 8,
  parameter int REF_W     = 8,
  parameter int RSP_REF_W = 3,
  parameter int STEP_W    = 4,
  parameter int SEL_W     = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  walkCtl_t              ctl,
  input  logic [SEL_W-1:0]      levelIdx,
  input  logic                  lastLevel,
  input  logic [STEP_W-1:0]     step,
  input  logic [VA_W-1:0]       gva,
  input  logic [PA_W-1:0]       guestRoot,
  input  logic [PA_W-1:0]       s2Root,
  input  logic [PA_W-1:0]       s2RspHpa,
  input  logic [RSP_REF_W-1:0]  s2RspRefs,
  input  logic [PA_W-OFF_W-1:0] memRspFrame,
  input  logic                  memRspPresent,
  output logic [PA_W-1:0]       curGpa,
  output logic [PA_W-1:0]       rootPtr,
  output logic [PA_W-1:0]       memAddr,
  output logic                  entryPresent,
  output logic [PA_W-1:0]       hpa,
  output logic [1:0]            fault,
  output logic [STEP_W-1:0]     faultStep,
  output logic [REF_W-1:0]      refCount
);

  localparam int SCALE_W = $clog2(ENTRY_B);

  logic [VA_W-1:0]   gvaQ;
  logic [PA_W-1:0]   tblBase;
  logic [REF_W-1:0]  refRun, refNext;
  faultKind_e        faultQ;
  logic [IDX_W-1:0]  idxArr [LEVELS];
  logic [IDX_W-1:0]  idxSel;

  // One index field per guest level, top level in the highest bits.
  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idxArr[g] = gvaQ[OFF_W + (LEVELS - g) * IDX_W - 1 -: IDX_W];
  end

  assign idxSel       = idxArr[levelIdx];
  assign memAddr      = tblBase + PA_W'({idxSel, {SCALE_W{1'b0}}});
  assign entryPresent = memRspPresent;

  assign refNext = refRun
                 + (ctl.addS2Refs ? REF_W'(s2RspRefs) : REF_W'(0))
                 + (ctl.addOne ? REF_W'(1) : REF_W'(0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gvaQ      <= '0;
      curGpa    <= '0;
      rootPtr   <= '0;
      tblBase   <= '0;
      refRun    <= '0;
      hpa       <= '0;
      faultQ    <= FLT_NONE;
      faultStep <= '0;
      refCount  <= '0;
    end else begin
      if (ctl.loadRoot) begin
        gvaQ    <= gva;
        curGpa  <= guestRoot;
        rootPtr <= s2Root;
        refRun  <= '0;
      end else begin
        refRun <= refNext;
      end
      if (ctl.loadBase) tblBase <= s2RspHpa;
      if (ctl.loadNext) begin
        curGpa <= lastLevel ? {memRspFrame, gvaQ[OFF_W-1:0]}
                            : {memRspFrame, {OFF_W{1'b0}}};
      end
      if (ctl.finish) begin
        hpa       <= (ctl.kind == FLT_NONE) ? s2RspHpa : '0;
        faultQ    <= ctl.kind;
        faultStep <= step;
        refCount  <= refNext;
      end
    end
  end

  assign fault = faultQ;

endmodule

// File: rtl/nested_walk_seq.sv
module nested_walk_seq
  import nws_pkg::*;
#(
  parameter int PA_W      = 52,
  parameter int VA_W      = 48,
  parameter int LEVELS    = 4,
  parameter int IDX_W     = 9,
  parameter int OFF_W     = 12,
  parameter int ENTRY_B   = 8,
  parameter int REF_W     = 8,
  parameter int RSP_REF_W = 3,
  localparam int LVL_W    = $clog2(LEVELS + 1),
  localparam int STEP_W   = $clog2(2 * LEVELS + 2),
  localparam int SEL_W    = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [VA_W-1:0]       gva,
  input  logic [PA_W-1:0]       guestRoot,
  input  logic [PA_W-1:0]       s2Root,
  output logic                  s2ReqValid,
  output logic [PA_W-1:0]       s2ReqGpa,
  output logic [PA_W-1:0]       s2ReqRoot,
  input  logic                  s2RspValid,
  input  logic [PA_W-1:0]       s2RspHpa,
  input  logic                  s2RspFault,
  input  logic [RSP_REF_W-1:0]  s2RspRefs,
  output logic                  memReq,
  output logic [PA_W-1:0]       memAddr,
  input  logic                  memRspValid,
  input  logic [PA_W-OFF_W-1:0] memRspFrame,
  input  logic                  memRspPresent,
  output logic                  done,
  output logic [PA_W-1:0]       hpa,
  output logic [1:0]            fault,
  output logic [STEP_W-1:0]     faultStep,
  output logic [REF_W-1:0]      refCount
);

  walkCtl_t          ctl;
  logic [SEL_W-1:0]  levelIdx;
  logic              lastLevel;
  logic [STEP_W-1:0] step;
  logic              entryPresent;

  nws_control #(
    .LEVELS(LEVELS), .LVL_W(LVL_W), .STEP_W(STEP_W), .SEL_W(SEL_W)
  ) u_control (
    .clk(clk), .rst_n(rst_n), .start(start),
    .s2RspValid(s2RspValid), .s2RspFault(s2RspFault),
    .memRspValid(memRspValid), .entryPresent(entryPresent),
    .ctl(ctl), .levelIdx(levelIdx), .lastLevel(lastLevel), .step(step),
    .s2ReqValid(s2ReqValid), .memReq(memReq), .done(done)
  );

  nws_datapath #(
    .PA_W(PA_W), .VA_W(VA_W), .LEVELS(LEVELS), .IDX_W(IDX_W),
    .OFF_W(OFF_W), .ENTRY_B(ENTRY_B), .REF_W(REF_W),
    .RSP_REF_W(RSP_REF_W), .STEP_W(STEP_W), .SEL_W(SEL_W)
  ) u_datapath (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .levelIdx(levelIdx),
    .lastLevel(lastLevel), .step(step), .gva(gva),
    .guestRoot(guestRoot), .s2Root(s2Root), .s2RspHpa(s2RspHpa),
    .s2RspRefs(s2RspRefs), .memRspFrame(memRspFrame),
    .memRspPresent(memRspPresent), .curGpa(s2ReqGpa),
    .rootPtr(s2ReqRoot), .memAddr(memAddr), .entryPresent(entryPresent),
    .hpa(hpa), .fault(fault), .faultStep(faultStep), .refCount(refCount)
  );

endmodule

// File: rtl/nws_checker.sv
module nws_checker #(
  parameter int LEVELS = 4,
  parameter int STEP_W = 4,
  parameter int PA_W   = 52,
  parameter int REF_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s2ReqValid,
  input logic              memReq,
  input logic              s2RspValid,
  input logic              memRspValid,
  input logic              done,
  input logic [PA_W-1:0]   hpa,
  input logic [1:0]        fault,
  input logic [STEP_W-1:0] faultStep,
  input logic [REF_W-1:0]  refCount
);

  logic pend;
  always_ff @(posedge clk) begin
    if (!rst_n) pend <= 1'b0;
    else if (s2ReqValid || memReq) pend <= 1'b1;
    else if (s2RspValid || memRspValid) pend <= 1'b0;
  end

  AST_NO_DUAL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(s2ReqValid && memReq)); // R3

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !(s2RspValid || memRspValid)) |-> !(s2ReqValid || memReq)); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({hpa, fault, faultStep, refCount})); // R10

  AST_OK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault == 2'd0) |-> faultStep == STEP_W'(2 * LEVELS)); // R6

  AST_GUEST_ODD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault == 2'd1) |-> (faultStep[0] && hpa == '0)); // R8

  AST_STAGE2_EVEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault == 2'd2) |-> (!faultStep[0] && hpa == '0)); // R9

  AST_NO_REQ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(s2ReqValid || memReq)); // R8

endmodule

bind nested_walk_seq nws_checker #(
  .LEVELS(LEVELS), .STEP_W(STEP_W), .PA_W(PA_W), .REF_W(REF_W)
) u_nws_checker (
  .clk(clk), .rst_n(rst_n), .s2ReqValid(s2ReqValid), .memReq(memReq),
  .s2RspValid(s2RspValid), .memRspValid(memRspValid), .done(done),
  .hpa(hpa), .fault(fault), .faultStep(faultStep), .refCount(refCount)
);

// File: tb/nested_walk_seq_bench.sv
`timescale 1ns/1ps
module nested_walk_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [47:0] gva = '0;
  logic [51:0] guestRoot = '0, s2Root = '0;
  logic        s2ReqValid, memReq, done;
  logic [51:0] s2ReqGpa, s2ReqRoot, memAddr, hpa;
  logic        s2RspValid = 1'b0, s2RspFault = 1'b0;
  logic [51:0] s2RspHpa = '0;
  logic [2:0]  s2RspRefs = '0;
  logic        memRspValid = 1'b0, memRspPresent = 1'b0;
  logic [39:0] memRspFrame = '0;
  logic [1:0]  fault;
  logic [3:0]  faultStep;
  logic [7:0]  refCount;

  always #10 clk = ~clk;

  nested_walk_seq u_nested_walk_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .gva(gva),
    .guestRoot(guestRoot), .s2Root(s2Root), .s2ReqValid(s2ReqValid),
    .s2ReqGpa(s2ReqGpa), .s2ReqRoot(s2ReqRoot), .s2RspValid(s2RspValid),
    .s2RspHpa(s2RspHpa), .s2RspFault(s2RspFault), .s2RspRefs(s2RspRefs),
    .memReq(memReq), .memAddr(memAddr), .memRspValid(memRspValid),
    .memRspFrame(memRspFrame), .memRspPresent(memRspPresent), .done(done),
    .hpa(hpa), .fault(fault), .faultStep(faultStep), .refCount(refCount)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference models of the walker and of the guest tables.
  function automatic logic [51:0] s2Map(input logic [51:0] root, input logic [51:0] a);
    return {a[51:12] ^ root[51:12] ^ 40'h3CA5F01E2D, a[11:0]};
  endfunction

  function automatic logic [39:0] frameAt(input logic [51:0] a);
    return a[51:12] + {31'b0, a[11:3]} + 40'h0000012345;
  endfunction

  // Current walk setup and expectations.
  logic [51:0] curRoot;
  int          gFaultAt = 9, sFaultAt = 9;
  logic [51:0] expS2Gpa [5];
  logic [51:0] expRdAddr [4];
  logic [51:0] expHpa;
  int          s2Idx = 0, rdIdx = 0;

  task automatic calcExp(input logic [47:0] va, input logic [51:0] gRoot, input logic [51:0] sRoot);
    logic [51:0] a, base;
    logic [39:0] fr;
    a = gRoot;
    for (int l = 0; l < 4; l++) begin
      expS2Gpa[l] = a;
      base = s2Map(sRoot, a);
      expRdAddr[l] = base + {40'b0, va[47 - 9*l -: 9], 3'b000};
      fr = frameAt(expRdAddr[l]);
      a = (l == 3) ? {fr, va[11:0]} : {fr, 12'h000};
    end
    expS2Gpa[4] = a;
    expHpa = s2Map(sRoot, a);
  endtask

  // Second-stage walker model.
  logic        s2Pend = 1'b0;
  int          s2Cnt = 0;
  logic [51:0] s2LatGpa, s2LatRoot;
  always @(posedge clk) begin
    s2RspValid <= 1'b0;
    if (rst_n && s2ReqValid) begin
      if (s2Idx < 5) chk("R3/R5 translation gpa", {12'b0, s2ReqGpa}, {12'b0, expS2Gpa[s2Idx]});
      chk("R2 root on request", {12'b0, s2ReqRoot}, {12'b0, curRoot});
      s2Pend    <= 1'b1;
      s2Cnt     <= int'($urandom % 4);
      s2LatGpa  <= s2ReqGpa;
      s2LatRoot <= s2ReqRoot;
    end else if (s2Pend) begin
      if (s2Cnt == 0) begin
        s2Pend     <= 1'b0;
        s2RspValid <= 1'b1;
        if (s2Idx == sFaultAt) begin
          s2RspFault <= 1'b1;
          s2RspRefs  <= 3'd2;
          s2RspHpa   <= {$urandom, 20'hABCDE};
        end else begin
          s2RspFault <= 1'b0;
          s2RspRefs  <= 3'd4;
          s2RspHpa   <= s2Map(s2LatRoot, s2LatGpa);
        end
        s2Idx <= s2Idx + 1;
      end else begin
        s2Cnt <= s2Cnt - 1;
      end
    end
  end

  // Guest table memory model.
  logic        rdPend = 1'b0;
  int          rdCnt = 0;
  logic [51:0] rdLatAddr;
  always @(posedge clk) begin
    memRspValid <= 1'b0;
    if (rst_n && memReq) begin
      if (rdIdx < 4) chk("R4 entry address", {12'b0, memAddr}, {12'b0, expRdAddr[rdIdx]});
      rdPend    <= 1'b1;
      rdCnt     <= int'($urandom % 4);
      rdLatAddr <= memAddr;
    end else if (rdPend) begin
      if (rdCnt == 0) begin
        rdPend        <= 1'b0;
        memRspValid   <= 1'b1;
        memRspPresent <= (rdIdx != gFaultAt);
        memRspFrame   <= frameAt(rdLatAddr);
        rdIdx <= rdIdx + 1;
      end else begin
        rdCnt <= rdCnt - 1;
      end
    end
  end

  task automatic runWalk(input logic [47:0] va, input logic [51:0] gRoot,
                         input logic [51:0] sRoot, input int gAt, input int sAt);
    int cyc;
    logic [51:0] hold;
    int expS2, expRd, expStep, expRefs, expFault;
    gFaultAt = gAt;
    sFaultAt = sAt;
    curRoot  = sRoot;
    calcExp(va, gRoot, sRoot);
    @(negedge clk);
    s2Idx = 0;
    rdIdx = 0;
    gva = va; guestRoot = gRoot; s2Root = sRoot; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    gva = {$urandom, 16'h5A5A}; guestRoot = {$urandom, 20'h0F0F0}; s2Root = {$urandom, 20'h12345};
    cyc = 0;
    while (!done && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
    chk("R3 walk completes", {63'b0, done}, 64'd1);
    if (sAt < 5) begin
      expFault = 2; expStep = 2 * sAt; expRefs = 5 * sAt + 2;
      expS2 = sAt + 1; expRd = sAt;
    end else if (gAt < 4) begin
      expFault = 1; expStep = 2 * gAt + 1; expRefs = 5 * gAt + 5;
      expS2 = gAt + 1; expRd = gAt + 1;
    end else begin
      expFault = 0; expStep = 8; expRefs = 24; expS2 = 5; expRd = 4;
    end
    if (expFault == 0) chk("R6 final hpa", {12'b0, hpa}, {12'b0, expHpa});
    else               chk("R8/R9 hpa zero on fault", {12'b0, hpa}, 64'd0);
    chk("R6/R8/R9 fault code", {62'b0, fault}, 64'(expFault));
    chk("R6/R8/R9 fault step", {60'b0, faultStep}, 64'(expStep));
    chk("R7 reference count", {56'b0, refCount}, 64'(expRefs));
    hold = hpa;
    repeat (6) @(negedge clk);
    chk("R10 done one cycle", {63'b0, done}, 64'd0);
    chk("R10 result held", {12'b0, hpa}, {12'b0, hold});
    chk("R3/R8/R9 translations issued", 64'(s2Idx), 64'(expS2));
    chk("R3/R8/R9 reads issued", 64'(rdIdx), 64'(expRd));
  endtask

  function automatic logic [51:0] rndPage();
    return {$urandom, 8'h00, 12'h000};
  endfunction

  logic finished = 1'b0;

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done low", {63'b0, done}, 64'd0);
    chk("R1 s2ReqValid low", {63'b0, s2ReqValid}, 64'd0);
    chk("R1 memReq low", {63'b0, memReq}, 64'd0);
    chk("R1 fault zero", {62'b0, fault}, 64'd0);
    chk("R1 refCount zero", {56'b0, refCount}, 64'd0);

    // Directed corner cases.
    runWalk(48'h0, 52'h0000000001000, 52'h00000ABCDE000, 9, 9);
    runWalk(48'hFFFFFFFFFFFF, 52'h0001234567000, 52'h0008765432000, 9, 9);
    runWalk(48'h8040201FFABC, 52'h0000ABC000000, 52'h0000000000000, 9, 9);
    for (int k = 0; k < 4; k++)
      runWalk(48'h123456789ABC, rndPage(), rndPage(), k, 9);
    runWalk(48'h0F0F0F0F0F0F, rndPage(), rndPage(), 9, 0);
    runWalk(48'h0F0F0F0F0F0F, rndPage(), rndPage(), 9, 2);
    runWalk(48'h0F0F0F0F0F0F, rndPage(), rndPage(), 9, 4);

    // Random walks.
    for (int i = 0; i < 60; i++) begin
      int mode, g, s;
      mode = int'($urandom % 4);
      g = 9; s = 9;
      if (mode == 2) g = int'($urandom % 4);
      if (mode == 3) s = int'($urandom % 5);
      runWalk({$urandom, 16'($urandom)}, rndPage(), {$urandom, 20'($urandom)}, g, s);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog R3 actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule